// File: doc/BRIEF.md
# Interrupt redirection controller register file

This block routes a set of interrupt input pins to an interrupt delivery port. Each pin owns a 64-bit routing entry that sets the vector, delivery mode, destination mode and destination sent when the pin fires. The entry also sets how the pin is sensed: a polarity bit, a choice of edge or level, and a mask. When an unmasked pin fires, the block raises a pending flag for it. It then presents one delivery request per firing on a valid/ready port and serves the lowest-numbered pending pin first.

Software reaches every register indirectly. It writes a register number to the index location at byte offset 0x00, and the data window at byte offset 0x10 then reads or writes the selected 32-bit register. Three registers sit at the bottom of the register space: an identifier, a read-only version and size word, and an arbitration identifier. The routing table follows them. Level-sensed pins are throttled by a remote-IRR flag. The flag is set when the request is accepted and cleared by an end-of-interrupt message that carries the same vector.

Top module: `irq_router`

## Requirements
- R1: A write to byte offset 0x00 loads the 8-bit index register, which reads back at offset 0x00 in bits 7:0 with the other bits zero. Reads and writes at offset 0x10 reach the register whose number the index holds.
- R2: Register 0x00 stores a writable 4-bit identifier in bits 27:24. Every other bit reads zero.
- R3: Register 0x01 is read-only and reads {8'h00, NPINS-1, 8'h00, VERSION}. With the defaults this is 0x00170011.
- R4: Register 0x02 stores a writable 4-bit arbitration identifier in bits 27:24. Every other bit reads zero.
- R5: The entry for pin n has its low word at register 0x10+2n and its high word at 0x11+2n. Low word: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13 (1 = active low), remote IRR 14, trigger 15 (1 = level), mask 16 (1 = disabled), and bits 31:17 read zero. High word: destination in 31:24, and the other bits read zero.
- R6: After reset every entry reads low word 0x00010000 and high word 0, and the index, identifier and arbitration registers read zero.
- R7: Software writes do not change the delivery-status and remote-IRR bits.
- R8: A masked entry never produces a request. Setting the mask on a pending entry withdraws its request and clears its delivery status.
- R9: An edge entry becomes pending on the clock edge that samples an inactive-to-active change of its pin, after polarity. It raises no further request while the pin stays active.
- R10: A level entry becomes pending while its pin is active and remote IRR is clear. Acceptance sets remote IRR. An end-of-interrupt whose vector matches clears it, and a non-matching vector leaves it set.
- R11: Delivery status reads 1 from the raise until the valid/ready handshake accepts the request. Meanwhile dlv_valid stays high and the request carries the entry's vector, delivery mode, destination mode and destination.
- R12: When several entries are pending, the request shows the lowest-numbered pin, and each acceptance moves on to the next higher pending pin.
- R13: An edge that arrives in the same cycle as the acceptance of that pin's request leaves the pin pending, so a second request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset: 0x00 index, 0x10 data window |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset (combinational) |
| irq_in | input | NPINS | Interrupt input pins, synchronous to clk |
| eoi_valid | input | 1 | End-of-interrupt message strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt message |
| dlv_valid | output | 1 | A delivery request is present |
| dlv_ready | input | 1 | Consumer accepts the request |
| dlv_vector | output | 8 | Vector of the request |
| dlv_dmode | output | 3 | Delivery mode of the request |
| dlv_dmod | output | 1 | Destination mode (0 physical, 1 logical) |
| dlv_dest | output | 8 | Destination of the request |

## Verification
Two functions can land in the same cycle on one pin: the acceptance that clears the pending flag, and a fresh edge that sets it again. The bench lowers a pending edge pin and then raises it in the very cycle it drives dlv_ready high. After that cycle the request must still be valid with the same vector, and one more acceptance must empty the port. A second overlap, an end-of-interrupt arriving while a level pin is still held active, is judged by whether the request reappears exactly once after the matching vector and never after a wrong one.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;

    // Byte offsets seen on the bus
    localparam logic [4:0] OFF_INDEX  = 5'h00;
    localparam logic [4:0] OFF_WINDOW = 5'h10;

    // Register numbers reached through the window
    localparam logic [7:0] RN_IDENT = 8'h00;
    localparam logic [7:0] RN_VERS  = 8'h01;
    localparam logic [7:0] RN_ARBID = 8'h02;
    localparam logic [7:0] RN_TABLE = 8'h10;

    // Software-writable part of one routing entry
    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       trig;
        logic       pol;
        logic       dmod;
        logic [2:0] dmode;
        logic [7:0] vec;
    } route_t;

    localparam route_t ROUTE_RESET = '{
        dest: 8'h00, mask: 1'b1, trig: 1'b0, pol: 1'b0,
        dmod: 1'b0, dmode: 3'd0, vec: 8'h00
    };

endpackage

// File: rtl/irq_sense.sv
`timescale 1ns/1ps
module irq_sense #(
    parameter int N = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    input  logic [N-1:0] pol,
    output logic [N-1:0] active,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        active = pins ^ pol;
        rise   = active & ~prev_q;
        prev_d = active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irq_pick.sv
`timescale 1ns/1ps
module irq_pick #(
    parameter int N  = 24,
    parameter int PW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [PW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = PW'(i);
        end
    end
endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router
    import irq_router_pkg::*;
#(
    parameter int         NPINS   = 24,
    parameter logic [7:0] VERSION = 8'h11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [NPINS-1:0] irq_in,
    input  logic             eoi_valid,
    input  logic [7:0]       eoi_vector,
    output logic             dlv_valid,
    input  logic             dlv_ready,
    output logic [7:0]       dlv_vector,
    output logic [2:0]       dlv_dmode,
    output logic             dlv_dmod,
    output logic [7:0]       dlv_dest
);
    localparam int         PW       = $clog2(NPINS);
    localparam logic [7:0] LAST_REG = 8'(32'(RN_TABLE) + 2 * NPINS - 1);
    localparam logic [7:0] MAX_ENT  = 8'(NPINS - 1);

    typedef struct packed {
        route_t [NPINS-1:0] tbl;
        logic   [NPINS-1:0] pend;
        logic   [NPINS-1:0] rirr;
        logic   [7:0]       index;
        logic   [3:0]       ident;
        logic   [3:0]       arbid;
    } state_t;

    state_t st_d, st_q;

    logic [NPINS-1:0] pol_v, trig_v, mask_v, active, rise;
    logic             any_pend;
    logic [PW-1:0]    grant;
    logic             win_sel, tbl_hit, hi_word, accept;
    logic [7:0]       tbl_off;
    logic [PW-1:0]    ent;
    logic [31:0]      win_data;
    wire              unused_bits = ^{bus_wdata[23:17], tbl_off[7:PW+1]};

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            pol_v[i]  = st_q.tbl[i].pol;
            trig_v[i] = st_q.tbl[i].trig;
            mask_v[i] = st_q.tbl[i].mask;
        end
    end

    irq_sense #(.N(NPINS)) u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins   (irq_in),
        .pol    (pol_v),
        .active (active),
        .rise   (rise)
    );

    irq_pick #(.N(NPINS), .PW(PW)) u_pick (
        .req (st_q.pend),
        .any (any_pend),
        .idx (grant)
    );

    // Window decode
    always_comb begin
        win_sel = (bus_addr == OFF_WINDOW);
        tbl_hit = (st_q.index >= RN_TABLE) && (st_q.index <= LAST_REG);
        tbl_off = st_q.index - RN_TABLE;
        ent     = tbl_off[PW:1];
        hi_word = tbl_off[0];
    end

    // Read path
    always_comb begin
        win_data = '0;
        case (st_q.index)
            RN_IDENT: win_data = {4'h0, st_q.ident, 24'h0};
            RN_VERS:  win_data = {8'h00, MAX_ENT, 8'h00, VERSION};
            RN_ARBID: win_data = {4'h0, st_q.arbid, 24'h0};
            default: begin
                if (tbl_hit) begin
                    if (hi_word) win_data = {st_q.tbl[ent].dest, 24'h0};
                    else win_data = {15'h0, st_q.tbl[ent].mask, st_q.tbl[ent].trig,
                                     st_q.rirr[ent], st_q.tbl[ent].pol, st_q.pend[ent],
                                     st_q.tbl[ent].dmod, st_q.tbl[ent].dmode,
                                     st_q.tbl[ent].vec};
                end
            end
        endcase
        if (bus_addr == OFF_INDEX) bus_rdata = {24'h0, st_q.index};
        else if (win_sel)          bus_rdata = win_data;
        else                       bus_rdata = '0;
    end

    // Delivery port
    always_comb begin
        dlv_valid  = any_pend;
        dlv_vector = st_q.tbl[grant].vec;
        dlv_dmode  = st_q.tbl[grant].dmode;
        dlv_dmod   = st_q.tbl[grant].dmod;
        dlv_dest   = st_q.tbl[grant].dest;
        accept     = dlv_valid && dlv_ready;
    end

    // Next state
    always_comb begin
        logic raise, eoi_hit, acc_i;
        st_d = st_q;
        if (bus_wr) begin
            if (bus_addr == OFF_INDEX) begin
                st_d.index = bus_wdata[7:0];
            end else if (win_sel) begin
                case (st_q.index)
                    RN_IDENT: st_d.ident = bus_wdata[27:24];
                    RN_ARBID: st_d.arbid = bus_wdata[27:24];
                    RN_VERS:  ;
                    default: begin
                        if (tbl_hit) begin
                            if (hi_word) begin
                                st_d.tbl[ent].dest = bus_wdata[31:24];
                            end else begin
                                st_d.tbl[ent].vec   = bus_wdata[7:0];
                                st_d.tbl[ent].dmode = bus_wdata[10:8];
                                st_d.tbl[ent].dmod  = bus_wdata[11];
                                st_d.tbl[ent].pol   = bus_wdata[13];
                                st_d.tbl[ent].trig  = bus_wdata[15];
                                st_d.tbl[ent].mask  = bus_wdata[16];
                            end
                        end
                    end
                endcase
            end
        end
        for (int i = 0; i < NPINS; i++) begin
            raise   = trig_v[i] ? (active[i] && !st_q.rirr[i] && !st_q.pend[i]) : rise[i];
            eoi_hit = eoi_valid && trig_v[i] && st_q.rirr[i] &&
                      (st_q.tbl[i].vec == eoi_vector);
            acc_i   = accept && (grant == PW'(i));
            st_d.rirr[i] = (st_q.rirr[i] && !eoi_hit) || (acc_i && trig_v[i]);
            st_d.pend[i] = ((st_q.pend[i] && !acc_i) || (raise && !mask_v[i]))
                           && !st_d.tbl[i].mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tbl   <= {NPINS{ROUTE_RESET}};
            st_q.pend  <= '0;
            st_q.rirr  <= '0;
            st_q.index <= '0;
            st_q.ident <= '0;
            st_q.arbid <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Assertions
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> !st_q.tbl[grant].mask) else $error("masked entry requesting"); // R8
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !dlv_ready && !bus_wr) |=> dlv_valid) else $error("request dropped"); // R11
    AST_RIRR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_ready && st_q.tbl[grant].trig) |=> st_q.rirr[$past(grant)])
        else $error("remote IRR not set"); // R10
    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> ((st_q.pend & ((NPINS'(1) << grant) - NPINS'(1))) == '0))
        else $error("lower pin skipped"); // R12
    AST_VERSION_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_WINDOW && st_q.index == RN_VERS) |-> bus_rdata == {8'h00, MAX_ENT, 8'h00, VERSION})
        else $error("version word wrong"); // R3
endmodule

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;
    localparam int N = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  irq_in = '0;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;
    logic          dlv_valid, dlv_ready = 1'b0, dlv_dmod;
    logic [7:0]    dlv_vector, dlv_dest;
    logic [2:0]    dlv_dmode;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_router u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .dlv_valid(dlv_valid),
        .dlv_ready(dlv_ready), .dlv_vector(dlv_vector), .dlv_dmode(dlv_dmode),
        .dlv_dmod(dlv_dmod), .dlv_dest(dlv_dest)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    function automatic logic [31:0] lo_word(input logic [7:0] vec, input logic [2:0] dm,
                                            input logic dmod, input logic pol,
                                            input logic trig, input logic mask);
        return {15'h0, mask, trig, 1'b0, pol, 1'b0, dmod, dm, vec};
    endfunction

    // Expected readback of a written low word while masked: status bits read zero
    function automatic logic [31:0] lo_expect(input logic [31:0] w);
        return (w | 32'h0001_0000) & 32'h0001_AFFF;
    endfunction

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] r, input logic [31:0] d);
        bus_write(5'h00, {24'h0, r});
        bus_write(5'h10, d);
    endtask

    task automatic reg_read(input logic [7:0] r, output logic [31:0] d);
        bus_write(5'h00, {24'h0, r});
        bus_addr = 5'h10;
        #1 d = bus_rdata;
    endtask

    task automatic set_pins(input logic [N-1:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
        #1;
    endtask

    task automatic do_accept();
        @(negedge clk);
        dlv_ready = 1'b1;
        @(negedge clk);
        dlv_ready = 1'b0;
        #1;
    endtask

    task automatic do_eoi(input logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [31:0] rd, lo, hi;
        logic [N-1:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6: reset state
        @(negedge clk);
        bus_addr = 5'h00; #1;
        chk("R6 index after reset", bus_rdata, 32'h0);
        chk("R6 no request after reset", {31'h0, dlv_valid}, 32'h0);
        reg_read(8'h10 + 8'd10, rd); chk("R6 low word reset", rd, 32'h0001_0000);
        reg_read(8'h11 + 8'd10, rd); chk("R6 high word reset", rd, 32'h0);
        reg_read(8'h00, rd); chk("R6 ident reset", rd, 32'h0);

        // R1, R2, R3, R4: fixed registers
        reg_write(8'h00, 32'hFFFF_FFFF);
        reg_read(8'h00, rd); chk("R2 ident field only", rd, 32'h0F00_0000);
        reg_write(8'h01, 32'hFFFF_FFFF);
        reg_read(8'h01, rd); chk("R3 version word", rd, 32'h0017_0011);
        reg_write(8'h02, 32'hA5A5_A5A5);
        reg_read(8'h02, rd); chk("R4 arbitration field", rd, 32'h0500_0000);
        bus_write(5'h00, 32'hFFFF_FF2A);
        bus_addr = 5'h00; #1;
        chk("R1 index readback", bus_rdata, 32'h0000_002A);

        // R5, R7: random table writes, kept masked
        for (int k = 0; k < 20; k++) begin
            int p;
            p  = $urandom_range(0, N - 1);
            lo = $urandom() | 32'h0001_0000;
            hi = $urandom();
            reg_write(8'(8'h10 + 2 * p), lo);
            reg_write(8'(8'h11 + 2 * p), hi);
            reg_read(8'(8'h10 + 2 * p), rd); chk("R5 R7 random low word", rd, lo_expect(lo));
            reg_read(8'(8'h11 + 2 * p), rd); chk("R5 random high word", rd, hi & 32'hFF00_0000);
        end

        // R9, R11: edge entry on pin 3
        reg_write(8'h11 + 8'd6, 32'h5A00_0000);
        reg_write(8'h10 + 8'd6, lo_word(8'h43, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0));
        v = irq_in; v[3] = 1'b1; set_pins(v);
        chk("R9 edge raises request", {31'h0, dlv_valid}, 32'h1);
        chk("R11 vector", {24'h0, dlv_vector}, 32'h43);
        chk("R11 delivery mode", {29'h0, dlv_dmode}, 32'h1);
        chk("R11 destination mode", {31'h0, dlv_dmod}, 32'h1);
        chk("R11 destination", {24'h0, dlv_dest}, 32'h5A);
        reg_read(8'h10 + 8'd6, rd); chk("R11 status pending", rd, 32'h0000_1943);
        do_accept();
        chk("R11 accepted clears request", {31'h0, dlv_valid}, 32'h0);
        reg_read(8'h10 + 8'd6, rd); chk("R11 status idle", rd, 32'h0000_0943);
        repeat (3) @(negedge clk);
        #1 chk("R9 held pin no repeat", {31'h0, dlv_valid}, 32'h0);

        // R13: new edge in the acceptance cycle
        v = irq_in; v[3] = 1'b0; set_pins(v);
        v[3] = 1'b1; set_pins(v);
        chk("R13 request present", {31'h0, dlv_valid}, 32'h1);
        v[3] = 1'b0; set_pins(v);
        @(negedge clk);
        irq_in[3] = 1'b1; dlv_ready = 1'b1;
        @(negedge clk);
        dlv_ready = 1'b0;
        #1 chk("R13 re-armed after accept", {31'h0, dlv_valid}, 32'h1);
        chk("R13 re-armed vector", {24'h0, dlv_vector}, 32'h43);
        do_accept();
        chk("R13 second accept empties", {31'h0, dlv_valid}, 32'h0);
        v = irq_in; v[3] = 1'b0; set_pins(v);

        // R9: active-low edge on pin 4
        v = irq_in; v[4] = 1'b1; set_pins(v);
        reg_write(8'h10 + 8'd8, lo_word(8'h44, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0));
        chk("R9 no request when inactive", {31'h0, dlv_valid}, 32'h0);
        v[4] = 1'b0; set_pins(v);
        chk("R9 falling edge active low", {31'h0, dlv_valid}, 32'h1);
        chk("R9 active low vector", {24'h0, dlv_vector}, 32'h44);
        do_accept();

        // R10: level entry on pin 6
        reg_write(8'h10 + 8'd12, lo_word(8'h66, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        v = irq_in; v[6] = 1'b1; set_pins(v);
        chk("R10 level raises", {31'h0, dlv_valid}, 32'h1);
        do_accept();
        chk("R10 remote IRR blocks", {31'h0, dlv_valid}, 32'h0);
        reg_read(8'h10 + 8'd12, rd); chk("R10 remote IRR visible", rd, 32'h0000_C066);
        reg_write(8'h10 + 8'd12, lo_word(8'h66, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        reg_read(8'h10 + 8'd12, rd); chk("R7 write keeps remote IRR", rd, 32'h0000_C066);
        do_eoi(8'h65);
        @(negedge clk); #1;
        chk("R10 wrong vector EOI ignored", {31'h0, dlv_valid}, 32'h0);
        do_eoi(8'h66);
        @(negedge clk); #1;
        chk("R10 matching EOI re-raises", {31'h0, dlv_valid}, 32'h1);
        v = irq_in; v[6] = 1'b0; set_pins(v);
        do_accept();
        do_eoi(8'h66);
        @(negedge clk); #1;
        chk("R10 inactive level no request", {31'h0, dlv_valid}, 32'h0);

        // R8: mask behaviour on pin 7
        reg_write(8'h10 + 8'd14, lo_word(8'h77, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        v = irq_in; v[7] = 1'b1; set_pins(v);
        chk("R8 unmasked raises", {31'h0, dlv_valid}, 32'h1);
        reg_write(8'h10 + 8'd14, lo_word(8'h77, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1));
        #1 chk("R8 mask withdraws request", {31'h0, dlv_valid}, 32'h0);
        reg_read(8'h10 + 8'd14, rd); chk("R8 status cleared by mask", rd, 32'h0001_0077);
        v[7] = 1'b0; set_pins(v);
        v[7] = 1'b1; set_pins(v);
        repeat (2) @(negedge clk);
        #1 chk("R8 masked edge silent", {31'h0, dlv_valid}, 32'h0);
        v[7] = 1'b0; set_pins(v);

        // R12: directed priority
        reg_write(8'h10 + 8'd4,  lo_word(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        reg_write(8'h10 + 8'd18, lo_word(8'h99, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        reg_write(8'h10 + 8'd40, lo_word(8'hB4, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        v = irq_in; v[2] = 1'b1; v[9] = 1'b1; v[20] = 1'b1; set_pins(v);
        chk("R12 lowest first", {24'h0, dlv_vector}, 32'h22);
        do_accept();
        chk("R12 second", {24'h0, dlv_vector}, 32'h99);
        do_accept();
        chk("R12 third", {24'h0, dlv_vector}, 32'hB4);
        do_accept();
        chk("R12 drained", {31'h0, dlv_valid}, 32'h0);
        v[2] = 1'b0; v[9] = 1'b0; v[20] = 1'b0; set_pins(v);

        // R12: random subsets over pins 10..17
        for (int p = 10; p < 18; p++)
            reg_write(8'(8'h10 + 2 * p), lo_word(8'(8'h80 + p), 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        for (int r = 0; r < 6; r++) begin
            logic [7:0] sub;
            sub = 8'($urandom_range(1, 255));
            v = irq_in;
            for (int p = 10; p < 18; p++) v[p] = sub[p - 10];
            set_pins(v);
            for (int p = 10; p < 18; p++) begin
                if (sub[p - 10]) begin
                    chk("R12 random order valid", {31'h0, dlv_valid}, 32'h1);
                    chk("R12 random order vector", {24'h0, dlv_vector}, 32'(8'h80 + p));
                    do_accept();
                end
            end
            chk("R12 random drained", {31'h0, dlv_valid}, 32'h0);
            for (int p = 10; p < 18; p++) v[p] = 1'b0;
            set_pins(v);
        end

        report();
    end
endmodule